// File: doc/BRIEF.md
# VLAN Egress Tag Editor

This block sits in the transmit path of an Ethernet MAC and edits the 802.1Q tagging of each outgoing frame as the frame streams through, one byte per beat. The frame arrives without its FCS, and recomputing the FCS is left to a later stage. With the first byte of a frame, the block captures a per-frame command. The command holds an action (keep, insert, remove or remark), a target (customer tag with TPID 0x8100, or service tag with a programmable TPID), and a priority and VLAN ID for a new or rewritten tag.

The only tag position the block examines or writes is the one directly after the two MAC addresses (byte offset 12). A new tag becomes the outermost tag. A tag further in, such as the customer tag behind a service tag, is never touched. Removal drops four bytes, so the output has four idle cycles. Insertion adds four bytes, so the upstream source is held for four cycles. Remark rewrites only the 12-bit VID and leaves the priority and DEI bits alone.

Both stream ports use valid/ready. A byte moves on a cycle where valid and ready are both high. A source must hold valid and its data until ready arrives. The block holds its own output stable in the same way while `out_ready` is low. In pass-through phases `in_ready` follows `out_ready`, so back-pressure from downstream reaches upstream in the same cycle.

Top module: `vtag_egress_editor`

## Requirements
- R1: A byte moves when valid and ready are both high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_eof` keep their values into the next cycle. Input frames are at least 18 bytes long.
- R2: The command inputs are sampled only on the input beat that carries `in_sof`. Changing them later in the frame has no effect on that frame.
- R3: Action code 0 (keep) sends the frame out unchanged, with no stall cycle and no idle output cycle.
- R4: Action code 1 (insert) places four bytes between input bytes 11 and 12: TPID high byte, TPID low byte, {PCP[2:0], DEI=0, VID[11:8]}, VID[7:0]. The TPID is 0x8100 when `cfg_tgt_stag`=0 and `cfg_stag_tpid` when it is 1. Upstream is stalled for exactly four cycles.
- R5: Action code 2 (remove) drops input bytes 12..15 when bytes 12..13 equal the target TPID, which gives four accepted input beats without output. Otherwise the frame passes unchanged.
- R6: Action code 3 (remark), when bytes 12..13 equal the target TPID, replaces the low nibble of byte 14 with VID[11:8] and byte 15 with VID[7:0], and keeps the PCP and DEI bits. Without a match the frame is unchanged.
- R7: Only the tag at offset 12 is examined. A second tag behind it is never removed or rewritten, even when it matches the target.
- R8: After reset `out_valid` is low and `in_ready` is high, and the block waits for the first byte of a frame.
- R9: `out_sof` marks the first output byte and `out_eof` marks the last output byte of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts input byte |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| cfg_action | input | 2 | 0 keep, 1 insert, 2 remove, 3 remark |
| cfg_tgt_stag | input | 1 | 0 customer tag, 1 service tag |
| cfg_vid | input | 12 | VLAN ID for insert/remark |
| cfg_pcp | input | 3 | Priority for insert |
| cfg_stag_tpid | input | 16 | Service tag TPID |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output frame byte |
| out_sof | output | 1 | First output byte of frame |
| out_eof | output | 1 | Last output byte of frame |

## Verification
Two things can collide in a single cycle: downstream back-pressure and the cycles the block spends emitting bytes of its own, either the inserted tag or the replayed TPID bytes after a failed match. The bench provokes this by lowering `out_ready` at pseudo-random times and by inserting idle input cycles across mixed-action frames. A scoreboard then checks that every expected byte appears exactly once, in order, with correct markers. A second overlap is a command change on the cycle right after the start-of-frame beat. Every frame scrambles the command at that point, and the scoreboard shows whether the captured command was kept.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  localparam int TPID_W = 16;
  localparam int VID_W  = 12;
  localparam int PCP_W  = 3;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_INSERT = 2'd1,
    ACT_REMOVE = 2'd2,
    ACT_REMARK = 2'd3
  } vtag_act_e;

  typedef struct packed {
    vtag_act_e          act;
    logic               tgt_stag;
    logic [VID_W-1:0]   vid;
    logic [PCP_W-1:0]   pcp;
    logic [TPID_W-1:0]  stag_tpid;
  } vtag_cfg_t;

  typedef enum logic [2:0] {
    ST_HDR    = 3'd0,
    ST_INS    = 3'd1,
    ST_CAP    = 3'd2,
    ST_DROP   = 3'd3,
    ST_REPLAY = 3'd4,
    ST_BODY   = 3'd5
  } vtag_st_e;
endpackage

// File: rtl/vtag_cfg_latch.sv
module vtag_cfg_latch
  import vtag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  vtag_cfg_t cfg_d,
  output vtag_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_q <= '0;
    else if (capture) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/vtag_tag_build.sv
module vtag_tag_build
  import vtag_pkg::*;
#(
  parameter logic [TPID_W-1:0] CTAG_TPID = 16'h8100
) (
  input  vtag_cfg_t         cfg,
  input  logic [1:0]        idx,
  output logic [TPID_W-1:0] tpid,
  output logic [7:0]        tag_byte
);
  logic [15:0] tci;

  always_comb begin
    tpid = cfg.tgt_stag ? cfg.stag_tpid : CTAG_TPID;
    tci  = {cfg.pcp, 1'b0, cfg.vid};
    case (idx)
      2'd0:    tag_byte = tpid[15:8];
      2'd1:    tag_byte = tpid[7:0];
      2'd2:    tag_byte = tci[15:8];
      default: tag_byte = tci[7:0];
    endcase
  end
endmodule

// File: rtl/vtag_tpid_cmp.sv
module vtag_tpid_cmp
  import vtag_pkg::*;
(
  input  logic [7:0]        hi,
  input  logic [7:0]        lo,
  input  logic [TPID_W-1:0] tpid,
  output logic              hit
);
  assign hit = ({hi, lo} == tpid);
endmodule

// File: rtl/vtag_egress_editor.sv
module vtag_egress_editor
  import vtag_pkg::*;
#(
  parameter int                MAC_BYTES = 12,
  parameter logic [TPID_W-1:0] CTAG_TPID = 16'h8100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic [1:0]           cfg_action,
  input  logic                 cfg_tgt_stag,
  input  logic [VID_W-1:0]     cfg_vid,
  input  logic [PCP_W-1:0]     cfg_pcp,
  input  logic [TPID_W-1:0]    cfg_stag_tpid,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_data,
  output logic                 out_sof,
  output logic                 out_eof
);
  localparam int HCNT_W = $clog2(MAC_BYTES);
  localparam logic [HCNT_W-1:0] HDR_LAST = HCNT_W'(MAC_BYTES - 1);
  localparam int TAG_BYTES = (TPID_W + PCP_W + 1 + VID_W) / 8;
  localparam logic [1:0] TAG_LAST  = 2'(TAG_BYTES - 1);
  localparam logic [1:0] BODY_DONE = 2'd2;

  vtag_st_e          st;
  logic [HCNT_W-1:0] hdr_cnt;
  logic [1:0]        sub_cnt;
  logic [1:0]        body_idx;
  logic [7:0]        buf_hi, buf_lo;
  logic              tag_hit, edit_en;
  logic              in_acc, out_acc;
  logic              cmp_hit;
  logic [TPID_W-1:0] tgt_tpid;
  logic [7:0]        tag_byte;
  vtag_cfg_t         cfg_d, cfg_q;

  assign in_acc  = in_valid & in_ready;
  assign out_acc = out_valid & out_ready;

  always_comb begin
    cfg_d.act       = vtag_act_e'(cfg_action);
    cfg_d.tgt_stag  = cfg_tgt_stag;
    cfg_d.vid       = cfg_vid;
    cfg_d.pcp       = cfg_pcp;
    cfg_d.stag_tpid = cfg_stag_tpid;
  end

  vtag_cfg_latch u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (in_acc && in_sof && st == ST_HDR),
    .cfg_d   (cfg_d),
    .cfg_q   (cfg_q)
  );

  vtag_tag_build #(.CTAG_TPID(CTAG_TPID)) u_tag (
    .cfg      (cfg_q),
    .idx      (sub_cnt),
    .tpid     (tgt_tpid),
    .tag_byte (tag_byte)
  );

  vtag_tpid_cmp u_cmp (
    .hi   (buf_hi),
    .lo   (in_data),
    .tpid (tgt_tpid),
    .hit  (cmp_hit)
  );

  // Output and ready steering per phase
  always_comb begin
    out_valid = 1'b0;
    in_ready  = 1'b0;
    out_data  = in_data;
    out_sof   = 1'b0;
    out_eof   = 1'b0;
    case (st)
      ST_HDR: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_sof   = in_sof;
        out_eof   = in_eof;
      end
      ST_INS: begin
        out_valid = 1'b1;
        out_data  = tag_byte;
      end
      ST_CAP, ST_DROP: begin
        in_ready  = 1'b1;
      end
      ST_REPLAY: begin
        out_valid = 1'b1;
        out_data  = (sub_cnt == 2'd0) ? buf_hi : buf_lo;
      end
      ST_BODY: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_eof   = in_eof;
        if (edit_en && body_idx == 2'd0)
          out_data = {in_data[7:4], cfg_q.vid[11:8]};
        else if (edit_en && body_idx == 2'd1)
          out_data = cfg_q.vid[7:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_HDR;
      hdr_cnt  <= '0;
      sub_cnt  <= '0;
      body_idx <= BODY_DONE;
      buf_hi   <= '0;
      buf_lo   <= '0;
      tag_hit  <= 1'b0;
      edit_en  <= 1'b0;
    end else begin
      case (st)
        ST_HDR: if (in_acc) begin
          if (in_eof) begin
            hdr_cnt <= '0;
          end else if (hdr_cnt == HDR_LAST) begin
            hdr_cnt  <= '0;
            sub_cnt  <= '0;
            edit_en  <= 1'b0;
            body_idx <= BODY_DONE;
            case (cfg_q.act)
              ACT_KEEP:   st <= ST_BODY;
              ACT_INSERT: st <= ST_INS;
              default:    st <= ST_CAP;
            endcase
          end else begin
            hdr_cnt <= hdr_cnt + 1'b1;
          end
        end
        ST_INS: if (out_ready) begin
          if (sub_cnt == TAG_LAST) st <= ST_BODY;
          else                     sub_cnt <= sub_cnt + 1'b1;
        end
        ST_CAP: if (in_acc) begin
          if (sub_cnt == 2'd0) begin
            buf_hi  <= in_data;
            sub_cnt <= 2'd1;
          end else begin
            buf_lo  <= in_data;
            tag_hit <= cmp_hit;
            sub_cnt <= 2'd0;
            st      <= (cfg_q.act == ACT_REMOVE && cmp_hit) ? ST_DROP : ST_REPLAY;
          end
        end
        ST_DROP: if (in_acc) begin
          if (sub_cnt == 2'd1) st <= ST_BODY;
          else                 sub_cnt <= sub_cnt + 1'b1;
        end
        ST_REPLAY: if (out_ready) begin
          if (sub_cnt == 2'd1) begin
            st       <= ST_BODY;
            edit_en  <= (cfg_q.act == ACT_REMARK) && tag_hit;
            body_idx <= 2'd0;
          end else begin
            sub_cnt <= sub_cnt + 1'b1;
          end
        end
        ST_BODY: if (in_acc) begin
          if (body_idx != BODY_DONE) body_idx <= body_idx + 1'b1;
          if (in_eof) begin
            st      <= ST_HDR;
            hdr_cnt <= '0;
          end
        end
        default: st <= ST_HDR;
      endcase
    end
  end

  // Output beat is held under back-pressure
  assert_out_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

  // Input contract: a frame never ends inside the tag window
  assert_eof_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && in_eof) |-> (st == ST_HDR || st == ST_BODY));

  // Insert: the first byte after the MAC addresses is the new TPID high byte, upstream held
  assert_insert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && st == ST_HDR && hdr_cnt == HDR_LAST && !in_eof && cfg_q.act == ACT_INSERT)
      |=> (out_valid && !in_ready && out_data == tgt_tpid[15:8]));

  // Remove with matching TPID: next cycle swallows input with no output
  assert_remove_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAP && in_acc && sub_cnt == 2'd1 && cfg_q.act == ACT_REMOVE && cmp_hit)
      |=> (!out_valid && in_ready));

  // Remark keeps the PCP and DEI nibble of the original tag
  assert_remark_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_acc && st == ST_BODY && edit_en && body_idx == 2'd0) |-> (out_data[7:4] == in_data[7:4]));
endmodule

// File: tb/vtag_egress_editor_tb_top.sv
module vtag_egress_editor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic [1:0]  cfg_action = '0;
  logic        cfg_tgt_stag = 1'b0;
  logic [11:0] cfg_vid = '0;
  logic [2:0]  cfg_pcp = '0;
  logic [15:0] cfg_stag_tpid = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_sof, out_eof;
  logic [7:0]  out_data;

  always #2 clk = ~clk;

  vtag_egress_editor dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .cfg_action(cfg_action), .cfg_tgt_stag(cfg_tgt_stag), .cfg_vid(cfg_vid),
    .cfg_pcp(cfg_pcp), .cfg_stag_tpid(cfg_stag_tpid),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  typedef struct {
    logic [7:0] d;
    logic       sof;
    logic       eof;
    string      req;
  } exp_t;

  exp_t        exp_q[$];
  int          checks = 0;
  int          errors = 0;
  bit          bp_en = 1'b0;
  bit          finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  // Downstream ready pattern
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = !bp_en || lfsr[0] || lfsr[3];
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected output byte", out_data, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_data == e.d, e.req, "data", out_data, e.d);
        check({out_sof, out_eof} == {e.sof, e.eof}, "R9", "sof/eof",
              {out_sof, out_eof}, {e.sof, e.eof});
      end
    end
  end

  function automatic void push_frame(input logic [7:0] f[$], input string req);
    for (int i = 0; i < f.size(); i++) begin
      exp_t e;
      e.d = f[i]; e.sof = (i == 0); e.eof = (i == f.size() - 1); e.req = req;
      exp_q.push_back(e);
    end
  endfunction

  // Reference model of the editing rules
  function automatic void model(input logic [7:0] f[$], input logic [1:0] act, input bit stg,
                                input logic [11:0] vid, input logic [2:0] pcp,
                                input logic [15:0] stpid, output logic [7:0] o[$]);
    logic [15:0] tgt;
    bit hit;
    tgt = stg ? stpid : 16'h8100;
    hit = ({f[12], f[13]} == tgt);
    o = {};
    for (int i = 0; i < f.size(); i++) begin
      if (act == 2'd1 && i == 12) begin
        o.push_back(tgt[15:8]); o.push_back(tgt[7:0]);
        o.push_back({pcp, 1'b0, vid[11:8]}); o.push_back(vid[7:0]);
      end
      if (act == 2'd2 && hit && i >= 12 && i <= 15) continue;
      if (act == 2'd3 && hit && i == 14)      o.push_back({f[i][7:4], vid[11:8]});
      else if (act == 2'd3 && hit && i == 15) o.push_back(vid[7:0]);
      else                                    o.push_back(f[i]);
    end
  endfunction

  function automatic void mk_frame(output logic [7:0] f[$], input int ntag,
                                   input logic [15:0] t1, input logic [15:0] c1,
                                   input logic [15:0] t2, input logic [15:0] c2,
                                   input int plen, input logic [7:0] seed);
    f = {};
    for (int i = 0; i < 12; i++) f.push_back(8'(seed + 8'(i * 7)));
    if (ntag >= 1) begin f.push_back(t1[15:8]); f.push_back(t1[7:0]); f.push_back(c1[15:8]); f.push_back(c1[7:0]); end
    if (ntag >= 2) begin f.push_back(t2[15:8]); f.push_back(t2[7:0]); f.push_back(c2[15:8]); f.push_back(c2[7:0]); end
    f.push_back(8'h08); f.push_back(8'h00);
    for (int i = 0; i < plen; i++) f.push_back(8'(seed ^ 8'(i * 13 + 5)));
  endfunction

  task automatic send(input logic [7:0] f[$], input logic [1:0] act, input bit stg,
                      input logic [11:0] vid, input logic [2:0] pcp, input logic [15:0] stpid,
                      input string req, input bit gaps, output int stalls, output int holes);
    logic [7:0] o[$];
    model(f, act, stg, vid, pcp, stpid, o);
    push_frame(o, req);
    stalls = 0; holes = 0;
    for (int i = 0; i < f.size(); i++) begin
      bit acc;
      if (gaps && lfsr[1]) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1; in_data = f[i];
      in_sof = (i == 0); in_eof = (i == f.size() - 1);
      if (i == 0) begin
        cfg_action = act; cfg_tgt_stag = stg; cfg_vid = vid; cfg_pcp = pcp; cfg_stag_tpid = stpid;
      end
      do begin
        @(negedge clk);
        acc = in_ready;
        if (!in_ready) stalls++;
        else if (!out_valid) holes++;
        @(posedge clk); #1;
      end while (!acc);
      // R2: scramble the command after the start beat
      cfg_action = ~act; cfg_tgt_stag = ~stg; cfg_vid = ~vid; cfg_pcp = ~pcp; cfg_stag_tpid = ~stpid;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R1", "bytes left in scoreboard", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] f[$];
    int st, ho;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    // R3 keep, untagged
    mk_frame(f, 0, 0, 0, 0, 0, 10, 8'h11);
    send(f, 2'd0, 1'b0, 12'h123, 3'd1, 16'h9100, "R3 R2", 1'b0, st, ho);
    check(st == 0 && ho == 0, "R3", "stall+idle cycles on keep", st + ho, 0);

    // R4 insert customer tag on untagged frame
    mk_frame(f, 0, 0, 0, 0, 0, 8, 8'h22);
    send(f, 2'd1, 1'b0, 12'hABC, 3'd6, 16'h9100, "R4 R2", 1'b0, st, ho);
    check(st == 4, "R4", "insert stall cycles", st, 4);

    // R4 insert service tag on customer-tagged frame -> double tag
    mk_frame(f, 1, 16'h8100, 16'h2005, 0, 0, 6, 8'h33);
    send(f, 2'd1, 1'b1, 12'h0F1, 3'd3, 16'h9100, "R4", 1'b0, st, ho);
    check(st == 4, "R4", "service insert stall cycles", st, 4);

    // R5 remove matching customer tag
    mk_frame(f, 1, 16'h8100, 16'hE07B, 0, 0, 6, 8'h44);
    send(f, 2'd2, 1'b0, 12'h000, 3'd0, 16'h9100, "R5 R2", 1'b0, st, ho);
    check(ho == 4, "R5", "idle output cycles on remove", ho, 4);

    // R5 remove service tag that is not there
    mk_frame(f, 1, 16'h8100, 16'h1234, 0, 0, 6, 8'h55);
    send(f, 2'd2, 1'b1, 12'h000, 3'd0, 16'h9100, "R5", 1'b0, st, ho);
    check(st == 2, "R5", "replay stall cycles on mismatch", st, 2);

    // R6 remark matching customer tag, PCP=5 DEI=1 kept
    mk_frame(f, 1, 16'h8100, 16'hB456, 0, 0, 6, 8'h66);
    send(f, 2'd3, 1'b0, 12'h9A7, 3'd0, 16'h9100, "R6 R2", 1'b0, st, ho);

    // R6 remark on untagged frame
    mk_frame(f, 0, 0, 0, 0, 0, 8, 8'h77);
    send(f, 2'd3, 1'b0, 12'h321, 3'd2, 16'h9100, "R6", 1'b0, st, ho);

    // R7 remove customer tag behind a service tag: unchanged
    mk_frame(f, 2, 16'h88A8, 16'h0064, 16'h8100, 16'h000A, 4, 8'h88);
    send(f, 2'd2, 1'b0, 12'h000, 3'd0, 16'h88A8, "R7", 1'b0, st, ho);

    // R7 remark outer service tag only
    mk_frame(f, 2, 16'h88A8, 16'h6064, 16'h8100, 16'h000A, 4, 8'h99);
    send(f, 2'd3, 1'b1, 12'h777, 3'd0, 16'h88A8, "R7 R6", 1'b0, st, ho);

    // R7 remove outer service tag, inner customer tag survives
    mk_frame(f, 2, 16'h9100, 16'h0064, 16'h8100, 16'h000A, 4, 8'hAA);
    send(f, 2'd2, 1'b1, 12'h000, 3'd0, 16'h9100, "R7 R5", 1'b0, st, ho);
    drain();

    // R1 back-pressure and idle input mixed run
    bp_en = 1'b1;
    for (int n = 0; n < 24; n++) begin
      logic [1:0] a;
      a = 2'(n);
      mk_frame(f, n % 3, (n % 2) ? 16'h9100 : 16'h8100, 16'(n * 37),
               16'h8100, 16'h0123, 3 + n % 5, 8'(n * 11));
      send(f, a, n[2], 12'(n * 91), 3'(n), 16'h9100, "R1 R9", 1'b1, st, ho);
    end
    drain();
    bp_en = 1'b0;
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule